// File: doc/BRIEF.md
# Outstanding Load Transaction Tracker

This block sits in the load/store unit of a simple in-order 32-bit core. It lets the core keep sending memory requests while earlier ones are still in flight, so the core hides the variable latency of a multi-level shared memory. Each accepted request takes one entry from a pool of parallel transaction slots, and the slot index travels with the request as its tag. A load also records its destination register. That register is marked pending in a per-register scoreboard until the response arrives.

Responses may return in any order, because near and far memory levels answer after different delays. A response names its slot by tag. The tracker frees that slot, hands the data and the recorded destination register to write-back, and clears the pending mark, all in the same cycle. A store holds its slot until its write acknowledge comes back, so a fence can wait for an empty pool. A separate query port lets the issue stage ask whether any of three registers still waits on a load. Issue is stalled only when every slot is busy or when the new request touches a register with a pending write. The ready signal depends only on registered state and on the issue operands, never on a response arriving in the same cycle.

The default pool holds 12 slots. That is one more than the longest zero-load round trip of 11 cycles, so a back-to-back stream of single-cycle issues never runs dry.

Top module: `olt_tracker`

## Requirements
- R1: After reset, issue_ready is 1, slots_empty is 1 and q_hazard is 0 for any query.
- R2: When issue_valid and issue_ready are both 1, mem_req_valid is 1 in the same cycle. mem_req_tag equals the lowest-numbered free slot, and address, write data and the store flag are passed through unchanged. At most one request is accepted per cycle.
- R3: From the cycle after a load to register rd (rd not 0) is accepted, q_hazard is 1 whenever q_rs1, q_rs2 or q_rd equals rd.
- R4: A response whose tag names a busy load slot gives wb_valid = 1 in the same cycle, with wb_rd equal to the recorded destination and wb_data equal to mem_rsp_data. From the next cycle that slot is free and the register is no longer pending.
- R5: Responses may arrive in any order. Only the tagged slot is freed, and the next allocation reuses it when it is the lowest free index.
- R6: While all slots are busy, issue_ready is 0. A response in such a cycle does not raise issue_ready in that cycle; it rises in the following cycle.
- R7: A load whose rd or rs1 is pending, or a store whose rs1 or rs2 is pending, sees issue_ready = 0 and produces no request. The stall lasts through the retiring response's cycle and ends in the next cycle.
- R8: A store (issue_store = 1) holds a slot until its acknowledge arrives. The acknowledge produces wb_valid = 0. slots_empty is 0 while any slot is busy and returns to 1 the cycle after the last response.
- R9: Register 0 is never marked pending. A load to register 0 takes a slot, but reads of register 0 never stall and never raise q_hazard.
- R10: A response whose tag names an idle slot, or a tag value of NUM_SLOTS or above, is ignored: wb_valid stays 0 and slot state does not change.
- R11: With issue_valid at 0, mem_req_valid is 0 and no slot is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Core presents a memory operation |
| issue_store | input | 1 | 1 = store, 0 = load |
| issue_rd | input | 5 | Load destination register |
| issue_rs1 | input | 5 | Address base source register |
| issue_rs2 | input | 5 | Store data source register |
| issue_addr | input | 32 | Memory address |
| issue_wdata | input | 32 | Store data |
| issue_ready | output | 1 | Operation may be accepted this cycle |
| mem_req_valid | output | 1 | Request toward the interconnect |
| mem_req_store | output | 1 | Request is a write |
| mem_req_tag | output | TAG_W | Slot index carried with the request |
| mem_req_addr | output | 32 | Request address |
| mem_req_wdata | output | 32 | Request write data |
| mem_rsp_valid | input | 1 | Response or write acknowledge present |
| mem_rsp_tag | input | TAG_W | Slot index returned with the response |
| mem_rsp_data | input | 32 | Load data |
| wb_valid | output | 1 | Load data ready for the register file |
| wb_rd | output | 5 | Register to write |
| wb_data | output | 32 | Data to write |
| q_rs1 | input | 5 | Scoreboard query register A |
| q_rs2 | input | 5 | Scoreboard query register B |
| q_rd | input | 5 | Scoreboard query register C |
| q_hazard | output | 1 | Some queried register has a pending load |
| slots_empty | output | 1 | No transaction outstanding |

## Verification
The hardest state to reach from the ports is a full pool that meets a response in the same cycle. Only then is it visible whether issue_ready leaks the freed slot combinationally. The stimulus issues twelve loads to distinct registers without answering any of them. It then holds a new load at the issue port while returning a middle tag, and checks that the stall holds for that cycle and that the freed index is the one granted next. A second hard case is a retiring load whose register the waiting request reads; it is driven the same way, with the response and the blocked issue in one cycle.

// File: rtl/olt_pkg.sv
package olt_pkg;
  localparam int REG_AW = 5;

  typedef enum logic {OP_LOAD = 1'b0, OP_STORE = 1'b1} mem_op_e;

  typedef struct packed {
    mem_op_e            op;
    logic [REG_AW-1:0]  rd;
  } slot_info_t;
endpackage

// File: rtl/olt_rst_sync.sv
module olt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/olt_slot_alloc.sv
module olt_slot_alloc #(
  parameter int N    = 12,
  parameter int TW   = 4
) (
  input  logic [N-1:0]  busy,
  output logic          any_free,
  output logic [TW-1:0] free_idx
);
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        any_free = 1'b1;
        free_idx = TW'(i);
      end
    end
  end
endmodule

// File: rtl/olt_slot_table.sv
module olt_slot_table
  import olt_pkg::*;
#(
  parameter int N  = 12,
  parameter int TW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic [TW-1:0]     alloc_idx,
  input  mem_op_e           alloc_op,
  input  logic [REG_AW-1:0] alloc_rd,
  input  logic              rsp_valid,
  input  logic [TW-1:0]     rsp_tag,
  output logic              rsp_hit,
  output logic              rsp_load,
  output logic [REG_AW-1:0] rsp_rd,
  output logic [N-1:0]      busy_vec
);
  logic [N-1:0] busy_q;
  slot_info_t   info_q [N];

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic       take, drop, busy_d, en;
    slot_info_t info_d;

    always_comb begin
      take   = alloc_en && (alloc_idx == TW'(g));
      drop   = rsp_valid && (rsp_tag == TW'(g)) && busy_q[g];
      en     = take || drop;
      busy_d = take;
      info_d = info_q[g];
      if (take) begin
        info_d.op = alloc_op;
        info_d.rd = alloc_rd;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy_q[g] <= 1'b0;
        info_q[g] <= '0;
      end else if (en) begin
        busy_q[g] <= busy_d;
        info_q[g] <= info_d;
      end
    end
  end

  always_comb begin
    rsp_hit  = 1'b0;
    rsp_load = 1'b0;
    rsp_rd   = '0;
    for (int i = 0; i < N; i++) begin
      if (rsp_valid && rsp_tag == TW'(i) && busy_q[i]) begin
        rsp_hit  = 1'b1;
        rsp_load = (info_q[i].op == OP_LOAD);
        rsp_rd   = info_q[i].rd;
      end
    end
  end

  assign busy_vec = busy_q;

  AST_ALLOC_FREE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !busy_q[alloc_idx]); // R2

  AST_RSP_FREES_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |=> !busy_q[$past(rsp_tag)]); // R4

  AST_ALLOC_MARKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |=> busy_q[$past(alloc_idx)]); // R5
endmodule

// File: rtl/olt_scoreboard.sv
module olt_scoreboard
  import olt_pkg::*;
#(
  parameter int NQ = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         set_en,
  input  logic [REG_AW-1:0]            set_rd,
  input  logic                         clr_en,
  input  logic [REG_AW-1:0]            clr_rd,
  input  logic [NQ-1:0][REG_AW-1:0]    lk_idx,
  output logic [NQ-1:0]                lk_hit
);
  localparam int NREG = 1 << REG_AW;

  logic [NREG-1:0] pend_q, pend_d;
  logic            pend_en;

  always_comb begin
    pend_en = set_en || clr_en;
    pend_d  = pend_q;
    if (clr_en) pend_d[clr_rd] = 1'b0;
    if (set_en) pend_d[set_rd] = 1'b1;
    pend_d[0] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  for (genvar q = 0; q < NQ; q++) begin : g_lookup
    assign lk_hit[q] = pend_q[lk_idx[q]];
  end

  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && set_rd != '0) |=> pend_q[$past(set_rd)]); // R3

  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !(set_en && set_rd == clr_rd)) |=> !pend_q[$past(clr_rd)]); // R4

  AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> !pend_q[0]); // R9
endmodule

// File: rtl/olt_tracker.sv
module olt_tracker
  import olt_pkg::*;
#(
  parameter int NUM_SLOTS = 12,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int TAG_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               issue_valid,
  input  logic               issue_store,
  input  logic [4:0]         issue_rd,
  input  logic [4:0]         issue_rs1,
  input  logic [4:0]         issue_rs2,
  input  logic [ADDR_W-1:0]  issue_addr,
  input  logic [DATA_W-1:0]  issue_wdata,
  output logic               issue_ready,
  output logic               mem_req_valid,
  output logic               mem_req_store,
  output logic [TAG_W-1:0]   mem_req_tag,
  output logic [ADDR_W-1:0]  mem_req_addr,
  output logic [DATA_W-1:0]  mem_req_wdata,
  input  logic               mem_rsp_valid,
  input  logic [TAG_W-1:0]   mem_rsp_tag,
  input  logic [DATA_W-1:0]  mem_rsp_data,
  output logic               wb_valid,
  output logic [4:0]         wb_rd,
  output logic [DATA_W-1:0]  wb_data,
  input  logic [4:0]         q_rs1,
  input  logic [4:0]         q_rs2,
  input  logic [4:0]         q_rd,
  output logic               q_hazard,
  output logic               slots_empty
);
  localparam int NQ = 6;

  logic                       rst_n_i;
  logic [NUM_SLOTS-1:0]       busy_vec;
  logic                       any_free;
  logic [TAG_W-1:0]           free_idx;
  logic                       accept, iss_hazard;
  logic                       rsp_hit, rsp_load;
  logic [REG_AW-1:0]          rsp_rd;
  logic [NQ-1:0][REG_AW-1:0]  lk_idx;
  logic [NQ-1:0]              lk_hit;
  mem_op_e                    iss_op;

  olt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  olt_slot_alloc #(.N(NUM_SLOTS), .TW(TAG_W)) u_alloc (
    .busy     (busy_vec),
    .any_free (any_free),
    .free_idx (free_idx)
  );

  assign lk_idx = {q_rd, q_rs2, q_rs1, issue_rd, issue_rs2, issue_rs1};

  olt_scoreboard #(.NQ(NQ)) u_sb (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .set_en (accept && !issue_store),
    .set_rd (issue_rd),
    .clr_en (rsp_hit && rsp_load),
    .clr_rd (rsp_rd),
    .lk_idx (lk_idx),
    .lk_hit (lk_hit)
  );

  always_comb begin
    iss_op     = issue_store ? OP_STORE : OP_LOAD;
    iss_hazard = lk_hit[0] || (issue_store ? lk_hit[1] : lk_hit[2]);
    issue_ready = any_free && !iss_hazard;
    accept      = issue_valid && issue_ready;
  end

  olt_slot_table #(.N(NUM_SLOTS), .TW(TAG_W)) u_table (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .alloc_en  (accept),
    .alloc_idx (free_idx),
    .alloc_op  (iss_op),
    .alloc_rd  (issue_rd),
    .rsp_valid (mem_rsp_valid),
    .rsp_tag   (mem_rsp_tag),
    .rsp_hit   (rsp_hit),
    .rsp_load  (rsp_load),
    .rsp_rd    (rsp_rd),
    .busy_vec  (busy_vec)
  );

  assign mem_req_valid = accept;
  assign mem_req_store = issue_store;
  assign mem_req_tag   = free_idx;
  assign mem_req_addr  = issue_addr;
  assign mem_req_wdata = issue_wdata;

  assign wb_valid    = rsp_hit && rsp_load;
  assign wb_rd       = rsp_rd;
  assign wb_data     = mem_rsp_data;
  assign q_hazard    = lk_hit[3] || lk_hit[4] || lk_hit[5];
  assign slots_empty = ~|busy_vec;

  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n_i)
    (&busy_vec) |-> !issue_ready); // R6

  AST_PENDING_RD_STALL: assert property (@(posedge clk) disable iff (!rst_n_i)
    (issue_valid && !issue_store && lk_hit[2]) |-> !mem_req_valid); // R7

  AST_WB_NEEDS_RSP: assert property (@(posedge clk) disable iff (!rst_n_i)
    wb_valid |-> mem_rsp_valid); // R4

  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n_i)
    !issue_valid |-> !mem_req_valid); // R11
endmodule

// File: tb/tb_olt_tracker.sv
module tb_olt_tracker;
  localparam int N  = 12;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic issue_valid, issue_store;
  logic [4:0] issue_rd, issue_rs1, issue_rs2;
  logic [31:0] issue_addr, issue_wdata;
  logic issue_ready, mem_req_valid, mem_req_store;
  logic [TW-1:0] mem_req_tag;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic mem_rsp_valid;
  logic [TW-1:0] mem_rsp_tag;
  logic [31:0] mem_rsp_data;
  logic wb_valid;
  logic [4:0] wb_rd;
  logic [31:0] wb_data;
  logic [4:0] q_rs1, q_rs2, q_rd;
  logic q_hazard, slots_empty;

  int checks = 0;
  int errors = 0;

  bit       mbusy  [N];
  bit       mstore [N];
  bit [4:0] mrd    [N];

  always #4 clk = ~clk;

  olt_tracker dut (
    .clk(clk), .rst_n(rst_n),
    .issue_valid(issue_valid), .issue_store(issue_store),
    .issue_rd(issue_rd), .issue_rs1(issue_rs1), .issue_rs2(issue_rs2),
    .issue_addr(issue_addr), .issue_wdata(issue_wdata), .issue_ready(issue_ready),
    .mem_req_valid(mem_req_valid), .mem_req_store(mem_req_store), .mem_req_tag(mem_req_tag),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_tag(mem_rsp_tag), .mem_rsp_data(mem_rsp_data),
    .wb_valid(wb_valid), .wb_rd(wb_rd), .wb_data(wb_data),
    .q_rs1(q_rs1), .q_rs2(q_rs2), .q_rd(q_rd), .q_hazard(q_hazard),
    .slots_empty(slots_empty)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int lowest_free();
    for (int i = 0; i < N; i++) if (!mbusy[i]) return i;
    return 0;
  endfunction

  task automatic do_issue(input bit st, input logic [4:0] rd, input logic [4:0] rs1,
                          input logic [4:0] rs2, input bit exp_rdy, input string req);
    int t;
    @(negedge clk);
    issue_valid = 1'b1; issue_store = st; issue_rd = rd; issue_rs1 = rs1; issue_rs2 = rs2;
    issue_addr = 32'h1000_0000 + 32'(rd) * 4; issue_wdata = 32'hD000_0000 | 32'(rs2);
    #1;
    chk({req, " issue_ready"}, 32'(issue_ready), 32'(exp_rdy));
    chk({req, " mem_req_valid"}, 32'(mem_req_valid), 32'(exp_rdy));
    if (exp_rdy) begin
      t = lowest_free();
      chk({req, " tag"}, 32'(mem_req_tag), 32'(t));
      chk({req, " addr"}, mem_req_addr, issue_addr);
      chk({req, " store flag"}, 32'(mem_req_store), 32'(st));
      mbusy[t] = 1'b1; mstore[t] = st; mrd[t] = rd;
    end
    @(posedge clk); #1;
    issue_valid = 1'b0;
  endtask

  task automatic do_rsp(input logic [TW-1:0] tag, input logic [31:0] data, input string req);
    bit exp_wb;
    exp_wb = (int'(tag) < N) && mbusy[int'(tag)] && !mstore[int'(tag)];
    @(negedge clk);
    mem_rsp_valid = 1'b1; mem_rsp_tag = tag; mem_rsp_data = data;
    #1;
    chk({req, " wb_valid"}, 32'(wb_valid), 32'(exp_wb));
    if (exp_wb) begin
      chk({req, " wb_rd"}, 32'(wb_rd), 32'(mrd[int'(tag)]));
      chk({req, " wb_data"}, wb_data, data);
    end
    @(posedge clk); #1;
    mem_rsp_valid = 1'b0;
    if (int'(tag) < N) mbusy[int'(tag)] = 1'b0;
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < N; i++) if (mbusy[i]) do_rsp(TW'(i), 32'hA500 + 32'(i), req);
  endtask

  task automatic query(input logic [4:0] a, input logic [4:0] b, input logic [4:0] c,
                       input bit exp, input string req);
    @(negedge clk);
    q_rs1 = a; q_rs2 = b; q_rd = c;
    #1;
    chk({req, " q_hazard"}, 32'(q_hazard), 32'(exp));
    q_rs1 = 0; q_rs2 = 0; q_rd = 0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R1 issue_ready", 32'(issue_ready), 1);
    chk("R1 slots_empty", 32'(slots_empty), 1);
    query(5'd7, 5'd9, 5'd31, 1'b0, "R1");
  endtask

  task automatic t_basic();
    do_issue(1'b0, 5'd5, 5'd1, 5'd0, 1'b1, "R2 load");
    query(5'd0, 5'd0, 5'd5, 1'b1, "R3 rd match");
    query(5'd5, 5'd0, 5'd0, 1'b1, "R3 rs1 match");
    query(5'd6, 5'd4, 5'd7, 1'b0, "R3 no match");
    do_rsp(TW'(0), 32'h1234_5678, "R4 retire");
    query(5'd5, 5'd5, 5'd5, 1'b0, "R4 cleared");
    @(negedge clk); #1;
    chk("R4 slots_empty", 32'(slots_empty), 1);
  endtask

  task automatic t_ooo();
    do_issue(1'b0, 5'd1, 5'd0, 5'd0, 1'b1, "R5 a");
    do_issue(1'b0, 5'd2, 5'd0, 5'd0, 1'b1, "R5 b");
    do_issue(1'b0, 5'd3, 5'd0, 5'd0, 1'b1, "R5 c");
    do_rsp(TW'(1), 32'hBEEF_0001, "R5 middle first");
    query(5'd2, 5'd0, 5'd0, 1'b0, "R5 r2 free");
    query(5'd1, 5'd3, 5'd0, 1'b1, "R5 others pending");
    do_issue(1'b0, 5'd4, 5'd0, 5'd0, 1'b1, "R5 reuse");
    drain("R5 drain");
  endtask

  task automatic t_full();
    for (int i = 0; i < N; i++) do_issue(1'b0, 5'(i + 1), 5'd0, 5'd0, 1'b1, "R6 fill");
    do_issue(1'b0, 5'd20, 5'd0, 5'd0, 1'b0, "R6 full stall");
    @(negedge clk);
    issue_valid = 1'b1; issue_store = 1'b0; issue_rd = 5'd21; issue_rs1 = 0; issue_rs2 = 0;
    mem_rsp_valid = 1'b1; mem_rsp_tag = TW'(7); mem_rsp_data = 32'h77;
    #1;
    chk("R6 no bypass ready", 32'(issue_ready), 0);
    chk("R6 no bypass req", 32'(mem_req_valid), 0);
    chk("R6 wb in full cycle", 32'(wb_valid), 1);
    chk("R6 wb rd", 32'(wb_rd), 8);
    @(posedge clk); #1;
    mem_rsp_valid = 1'b0; issue_valid = 1'b0; mbusy[7] = 1'b0;
    do_issue(1'b0, 5'd21, 5'd0, 5'd0, 1'b1, "R6 next cycle");
    drain("R6 drain");
  endtask

  task automatic t_hazard();
    do_issue(1'b0, 5'd9, 5'd0, 5'd0, 1'b1, "R7 producer");
    do_issue(1'b1, 5'd0, 5'd2, 5'd9, 1'b0, "R7 store rs2");
    do_issue(1'b1, 5'd0, 5'd9, 5'd2, 1'b0, "R7 store rs1");
    do_issue(1'b0, 5'd9, 5'd0, 5'd0, 1'b0, "R7 load rd");
    @(negedge clk);
    issue_valid = 1'b1; issue_store = 1'b0; issue_rd = 5'd10; issue_rs1 = 5'd9; issue_rs2 = 0;
    mem_rsp_valid = 1'b1; mem_rsp_tag = TW'(0); mem_rsp_data = 32'h99;
    #1;
    chk("R7 stall in retire cycle", 32'(issue_ready), 0);
    @(posedge clk); #1;
    mem_rsp_valid = 1'b0; issue_valid = 1'b0; mbusy[0] = 1'b0;
    do_issue(1'b0, 5'd10, 5'd9, 5'd0, 1'b1, "R7 released");
    drain("R7 drain");
  endtask

  task automatic t_store();
    do_issue(1'b1, 5'd0, 5'd3, 5'd4, 1'b1, "R8 store");
    @(negedge clk); #1;
    chk("R8 busy not empty", 32'(slots_empty), 0);
    do_rsp(TW'(0), 32'h0, "R8 ack");
    @(negedge clk); #1;
    chk("R8 empty after ack", 32'(slots_empty), 1);
  endtask

  task automatic t_zero();
    do_issue(1'b0, 5'd0, 5'd1, 5'd0, 1'b1, "R9 load x0");
    query(5'd0, 5'd0, 5'd0, 1'b0, "R9 x0 query");
    do_issue(1'b0, 5'd6, 5'd0, 5'd0, 1'b1, "R9 reader of x0");
    drain("R9 drain");
  endtask

  task automatic t_idle_rsp();
    do_rsp(TW'(3), 32'h3333, "R10 idle tag");
    do_rsp(TW'(14), 32'hEEEE, "R10 out of range tag");
    @(negedge clk); #1;
    chk("R10 still empty", 32'(slots_empty), 1);
    do_issue(1'b0, 5'd11, 5'd0, 5'd0, 1'b1, "R10 tag zero kept");
    drain("R10 drain");
  endtask

  task automatic t_no_valid();
    @(negedge clk);
    issue_valid = 1'b0; issue_rd = 5'd12;
    #1;
    chk("R11 no request", 32'(mem_req_valid), 0);
    @(posedge clk);
    @(negedge clk); #1;
    chk("R11 no slot taken", 32'(slots_empty), 1);
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    issue_valid = 0; issue_store = 0; issue_rd = 0; issue_rs1 = 0; issue_rs2 = 0;
    issue_addr = 0; issue_wdata = 0; mem_rsp_valid = 0; mem_rsp_tag = 0; mem_rsp_data = 0;
    q_rs1 = 0; q_rs2 = 0; q_rd = 0;
    for (int i = 0; i < N; i++) begin mbusy[i] = 0; mstore[i] = 0; mrd[i] = 0; end
    t_reset();
    t_basic();
    t_ooo();
    t_full();
    t_hazard();
    t_store();
    t_zero();
    t_idle_rsp();
    t_no_valid();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule